// File: doc/BRIEF.md
# UART Transmit Channel with Byte Queue

This block is the sending half of a serial port. A host writes bytes into a 16-entry queue through a simple write strobe. A shift stage takes the bytes out one at a time and sends each one on a single line as a framed character. The character starts with a low start bit. The data bits follow least significant bit first, then an optional parity bit, then one or two high stop bits. While nothing is being sent, the line rests high.

Two status flags tell the host how far the work has progressed. One flag says the queue has drained into the shift stage. The other says the line has fully gone quiet. An interrupt, which can be enabled, marks the moment the queue runs dry. An active-low ready strobe paces a DMA engine, either once per empty queue or for as long as the queue has a free slot. Bit timing comes from a 16-bit divisor: each bit lasts sixteen baud ticks.

Top module: `uart_tx_chan`

## Requirements
- R1: While no character is being sent (after reset, or once the last stop bit has ended), `txd` is 1.
- R2: Each character is sent in this order: a 0 start bit, then `len_sel`+5 data bits LSB first (`len_sel` 0..3 gives 5..8 bits), then a parity bit if `par_en`=1, then one stop bit at 1, or two when `stop2`=1.
- R3: With `par_even`=1 the parity bit makes the count of ones across the data and parity bits even. With `par_even`=0 it makes that count odd.
- R4: Every bit lasts 16×`divisor` clock cycles (a divisor of 0 counts as 1). When a further byte is queued at the end of a character, the next start bit follows the last stop bit with no gap.
- R5: The queue holds 16 bytes. A write arriving while it is full is dropped, and every byte already accepted is still sent, in write order.
- R6: `thre` is 1 after reset. It is 0 in the cycle after any write. It returns to 1 in the cycle after the shift stage takes the last queued byte.
- R7: `temt` is 1 after reset and clears together with `thre`. It returns to 1 only in the cycle after the last stop bit of the last queued byte ends.
- R8: When `thre` rises with `thre_ie`=1, `irq` rises in the same cycle. A write or an `iir_rd` pulse clears it. If `iir_rd` lands in the cycle where the rise is set, `irq` still rises. With `thre_ie`=0 it stays 0.
- R9: With `dma_demand`=0 (single mode), `tx_rdy_n` is 0 exactly while the queue is empty.
- R10: With `dma_demand`=1 (demand mode), `tx_rdy_n` is 0 exactly while the queue holds fewer than 16 bytes.
- R11: The frame format is captured when a byte enters the shift stage. Changing `len_sel`, `par_en`, `par_even` or `stop2` mid-character does not alter that character.
- R12: A write that lands in the same cycle as the shift stage takes the only queued byte keeps `thre` at 0 and does not raise `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe into the queue |
| wr_data | input | 8 | Byte to queue |
| iir_rd | input | 1 | Interrupt identification read pulse; clears `irq` |
| divisor | input | 16 | Baud divisor (clock cycles per baud tick) |
| len_sel | input | 2 | Data length minus 5 |
| par_en | input | 1 | Parity bit enable |
| par_even | input | 1 | 1 selects even parity, 0 odd |
| stop2 | input | 1 | 1 selects two stop bits |
| dma_demand | input | 1 | 0 single-transfer, 1 demand-transfer ready mode |
| thre_ie | input | 1 | Queue-empty interrupt enable |
| txd | output | 1 | Serial data line |
| thre | output | 1 | Queue empty flag |
| temt | output | 1 | Queue and shift stage both empty |
| irq | output | 1 | Queue-empty interrupt |
| tx_rdy_n | output | 1 | Active-low DMA ready |

## Verification
Two functions can land in the same clock edge: a host write, and the shift stage taking the last queued byte, which would set `thre` and `irq`. The bench provokes this by writing two bytes on consecutive edges into an idle channel, so the second write coincides with the first byte's load. It judges the result by seeing `thre` stay 0 and `irq` stay 0 right after that edge. A second collision places an `iir_rd` pulse on the load edge, where `irq` must still come up. Random bursts with random formats and divisors then confirm through a line decoder that neither collision corrupts the characters sent.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int DATA_W     = 8;
    localparam int FRAME_MAX  = 12;
    localparam int FRAME_CW   = 4;
    localparam int OVERSAMPLE = 16;
    localparam int DIV_W      = 16;
    localparam int Q_DEPTH    = 16;

    typedef struct packed {
        logic [1:0] len_sel;
        logic       par_en;
        logic       par_even;
        logic       stop2;
    } fmt_t;

    typedef struct packed {
        logic [FRAME_MAX-1:0] bits;
        logic [FRAME_CW-1:0]  nbits;
    } frame_t;

    // Builds the line pattern, first bit in position 0; spare positions stay high.
    function automatic frame_t make_frame(input logic [DATA_W-1:0] d, input fmt_t f);
        frame_t             fr;
        logic [FRAME_CW-1:0] dl;
        logic [FRAME_CW-1:0] pos;
        logic               acc;
        fr.bits    = '1;
        fr.bits[0] = 1'b0;
        dl  = FRAME_CW'(f.len_sel) + FRAME_CW'(5);
        acc = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (FRAME_CW'(i) < dl) begin
                fr.bits[i + 1] = d[i];
                acc = acc ^ d[i];
            end
        end
        pos = dl + FRAME_CW'(1);
        if (f.par_en) begin
            fr.bits[pos] = f.par_even ? acc : ~acc;
            pos = pos + FRAME_CW'(1);
        end
        pos = pos + (f.stop2 ? FRAME_CW'(2) : FRAME_CW'(1));
        fr.nbits = pos;
        return fr;
    endfunction

endpackage

// File: rtl/tx_byte_queue.sv
module tx_byte_queue #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         empty,
    output logic                         full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr, wr_nx, rd_nx;
    logic          push_ok, pop_ok;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem[rd_ptr];

    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
            assign wr_nx = wr_ptr + AW'(1);
            assign rd_nx = rd_ptr + AW'(1);
        end else begin : g_wrap
            assign wr_nx = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
            assign rd_nx = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_nx;
            if (pop_ok)  rd_ptr <= rd_nx;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH)) else $error("queue count past depth"); // R5
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> $stable(count)) else $error("write into full queue stored"); // R5
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] limit;

    assign limit = (divisor == '0) ? '0 : divisor - DIV_W'(1);
    assign tick  = (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || restart)  cnt <= '0;
        else if (cnt >= limit) cnt <= '0;
        else                 cnt <= cnt + DIV_W'(1);
    end
endmodule

// File: rtl/tx_frame_shifter.sv
module tx_frame_shifter
    import uart_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  fmt_t              fmt,
    input  logic              q_empty,
    input  logic [DATA_W-1:0] q_head,
    output logic              load,
    output logic              frame_end,
    output logic              txd
);
    localparam int SUB_W = $clog2(OVERSAMPLE);

    logic                  busy;
    logic [FRAME_MAX-1:0]  sh;
    logic [FRAME_CW-1:0]   bits_left;
    logic [SUB_W-1:0]      sub;
    logic                  bit_end;
    frame_t                nxt;

    assign bit_end   = busy && tick && (sub == SUB_W'(OVERSAMPLE - 1));
    assign frame_end = bit_end && (bits_left == FRAME_CW'(1));
    assign load      = !q_empty && (!busy || frame_end);
    assign nxt       = make_frame(q_head, fmt);
    assign txd       = busy ? sh[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            sh        <= '1;
            bits_left <= '0;
            sub       <= '0;
        end else if (load) begin
            busy      <= 1'b1;
            sh        <= nxt.bits;
            bits_left <= nxt.nbits;
            sub       <= '0;
        end else if (busy && tick) begin
            if (bit_end) begin
                sub       <= '0;
                sh        <= {1'b1, sh[FRAME_MAX-1:1]};
                bits_left <= bits_left - FRAME_CW'(1);
                if (bits_left == FRAME_CW'(1)) busy <= 1'b0;
            end else begin
                sub <= sub + SUB_W'(1);
            end
        end
    end

    AST_START_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> !txd) else $error("no start bit after load"); // R2
    AST_STOP_AT_END: assert property (@(posedge clk) disable iff (rst)
        frame_end |-> txd) else $error("last bit not a stop bit"); // R2
endmodule

// File: rtl/uart_tx_chan.sv
module uart_tx_chan
    import uart_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    input  logic        iir_rd,
    input  logic [15:0] divisor,
    input  logic [1:0]  len_sel,
    input  logic        par_en,
    input  logic        par_even,
    input  logic        stop2,
    input  logic        dma_demand,
    input  logic        thre_ie,
    output logic        txd,
    output logic        thre,
    output logic        temt,
    output logic        irq,
    output logic        tx_rdy_n
);
    localparam int CW = $clog2(Q_DEPTH + 1);

    fmt_t              cfg;
    logic [DATA_W-1:0] head;
    logic [CW-1:0]     count;
    logic              q_empty, q_full;
    logic              load, frame_end, tick;
    logic              drains;

    assign cfg = '{len_sel: len_sel, par_en: par_en, par_even: par_even, stop2: stop2};

    tx_byte_queue #(.DEPTH(Q_DEPTH), .W(DATA_W)) u_queue (
        .clk(clk), .rst(rst), .push(wr_en), .din(wr_data), .pop(load),
        .dout(head), .count(count), .empty(q_empty), .full(q_full)
    );

    baud_tick_gen #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst(rst), .restart(load), .divisor(divisor), .tick(tick)
    );

    tx_frame_shifter u_shift (
        .clk(clk), .rst(rst), .tick(tick), .fmt(cfg), .q_empty(q_empty),
        .q_head(head), .load(load), .frame_end(frame_end), .txd(txd)
    );

    // Last byte leaves the queue with no write landing on the same edge.
    assign drains = load && !wr_en && (count == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            thre <= 1'b1;
            temt <= 1'b1;
            irq  <= 1'b0;
        end else begin
            if (wr_en)       thre <= 1'b0;
            else if (drains) thre <= 1'b1;

            if (wr_en)                       temt <= 1'b0;
            else if (frame_end && !load)     temt <= 1'b1;

            if (drains && thre_ie)           irq <= 1'b1;
            else if (wr_en || iir_rd)        irq <= 1'b0;
        end
    end

    assign tx_rdy_n = dma_demand ? q_full : !q_empty;

    AST_THRE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !thre) else $error("thre set after write"); // R6
    AST_TEMT_NEEDS_THRE: assert property (@(posedge clk) disable iff (rst)
        temt |-> thre) else $error("temt without thre"); // R7
    AST_IRQ_WRITE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !irq) else $error("irq kept after write"); // R8
    AST_IDLE_MARK: assert property (@(posedge clk) disable iff (rst)
        temt |-> txd) else $error("line low while idle"); // R1
    AST_SINGLE_READY: assert property (@(posedge clk) disable iff (rst)
        (!dma_demand && thre) |-> !tx_rdy_n) else $error("single ready missing"); // R9
endmodule

// File: tb/tb_uart_tx_chan.sv
module tb_uart_tx_chan;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        iir_rd = 1'b0;
    logic [15:0] divisor = 16'd1;
    logic [1:0]  len_sel = 2'd3;
    logic        par_en = 1'b0;
    logic        par_even = 1'b0;
    logic        stop2 = 1'b0;
    logic        dma_demand = 1'b0;
    logic        thre_ie = 1'b1;
    logic        txd, thre, temt, irq, tx_rdy_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [11:0] q_bits[$];
    int          q_len[$];

    always #10 clk = ~clk;

    uart_tx_chan dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .iir_rd(iir_rd),
        .divisor(divisor), .len_sel(len_sel), .par_en(par_en), .par_even(par_even),
        .stop2(stop2), .dma_demand(dma_demand), .thre_ie(thre_ie),
        .txd(txd), .thre(thre), .temt(temt), .irq(irq), .tx_rdy_n(tx_rdy_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] ref_bits(input logic [7:0] d, input int dl,
                                             input bit pe, input bit pev, input bit s2,
                                             output int n);
        logic [11:0] b = '1;
        int k = 1;
        int ones = 0;
        b[0] = 1'b0;
        for (int i = 0; i < dl; i++) begin
            b[k] = d[i];
            ones += int'(d[i]);
            k++;
        end
        if (pe) begin
            b[k] = pev ? ones[0] : ~ones[0];
            k++;
        end
        k += s2 ? 2 : 1;
        n = k;
        return b;
    endfunction

    task automatic expect_byte(input logic [7:0] d);
        int n;
        logic [11:0] b;
        b = ref_bits(d, int'(len_sel) + 5, par_en, par_even, stop2, n);
        q_bits.push_back(b);
        q_len.push_back(n);
    endtask

    // Burst from an idle channel; writes past the 17th are dropped (one in shifter + 16 queued).
    task automatic burst(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == 1) chk(tx_rdy_n == (dma_demand ? 1'b0 : 1'b1), "R9/R10 ready after first write", tx_rdy_n, dma_demand ? 0 : 1);
            if (dma_demand && i == 16) chk(tx_rdy_n == 1'b0, "R10 one slot free", tx_rdy_n, 0);
            if (dma_demand && i == 17) chk(tx_rdy_n == 1'b1, "R10 queue full", tx_rdy_n, 1);
            wr_en   = 1'b1;
            wr_data = 8'($urandom);
            if (i < 17) expect_byte(wr_data);
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!temt) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Line decoder: samples each bit at its centre.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && txd === 1'b0) begin
                int d;
                d = (divisor == 0) ? 1 : int'(divisor);
                if (q_len.size() == 0) begin
                    chk(1'b0, "R5 unexpected character", 0, 1);
                    while (txd === 1'b0) @(negedge clk);
                end else begin
                    int n;
                    logic [11:0] eb, got;
                    n   = q_len.pop_front();
                    eb  = q_bits.pop_front();
                    got = '1;
                    repeat (8 * d) @(negedge clk);
                    got[0] = txd;
                    for (int i = 1; i < n; i++) begin
                        repeat (16 * d) @(negedge clk);
                        got[i] = txd;
                    end
                    chk(got == eb, "R2/R3/R4/R5 character bits", int'(got), int'(eb));
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog expired", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // Reset state
        chk(txd == 1'b1, "R1 idle mark", txd, 1);
        chk(thre == 1'b1, "R6 thre after reset", thre, 1);
        chk(temt == 1'b1, "R7 temt after reset", temt, 1);
        chk(irq == 1'b0, "R8 irq after reset", irq, 0);
        chk(tx_rdy_n == 1'b0, "R9 single ready when empty", tx_rdy_n, 0);

        // Single byte, 8N1, divisor 1: flag timing
        burst(1);
        chk(thre == 1'b0, "R6 thre cleared by write", thre, 0);
        chk(temt == 1'b0, "R7 temt cleared by write", temt, 0);
        chk(tx_rdy_n == 1'b1, "R9 single ready drops after write", tx_rdy_n, 1);
        @(negedge clk);
        chk(thre == 1'b1, "R6 thre set on load", thre, 1);
        chk(irq == 1'b1, "R8 irq raised", irq, 1);
        chk(txd == 1'b0, "R2 start bit", txd, 0);
        iir_rd = 1'b1;
        @(negedge clk);
        iir_rd = 1'b0;
        chk(irq == 1'b0, "R8 irq cleared by iir_rd", irq, 0);
        repeat (160 - 2) @(negedge clk);
        chk(temt == 1'b0, "R7 temt held through last stop bit", temt, 0);
        chk(txd == 1'b1, "R2 stop bit level", txd, 1);
        @(negedge clk);
        chk(temt == 1'b1, "R7 temt set after last stop bit", temt, 1);
        chk(txd == 1'b1, "R1 mark after character", txd, 1);
        wait_idle();

        // 6 data bits, even parity, two stop bits
        len_sel = 2'd1; par_en = 1'b1; par_even = 1'b1; stop2 = 1'b1;
        burst(3);
        wait_idle();

        // 5 data bits, odd parity, one stop bit, divisor 2
        len_sel = 2'd0; par_even = 1'b0; stop2 = 1'b0; divisor = 16'd2;
        burst(4);
        wait_idle();

        // Overflow in demand mode
        len_sel = 2'd3; par_en = 1'b0; divisor = 16'd1; dma_demand = 1'b1;
        burst(20);
        wait_idle();
        chk(q_len.size() == 0, "R5 accepted bytes all sent", q_len.size(), 0);
        dma_demand = 1'b0;

        // Write landing on the edge that takes the only queued byte
        burst(2);
        chk(thre == 1'b0, "R12 thre stays clear on write+load", thre, 0);
        chk(irq == 1'b0, "R12 no irq on write+load", irq, 0);
        wait_idle();

        // iir_rd on the same edge that raises irq
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'hA5; expect_byte(wr_data);
        @(negedge clk);
        wr_en = 1'b0; iir_rd = 1'b1;
        @(negedge clk);
        iir_rd = 1'b0;
        chk(irq == 1'b1, "R8 rise wins over coincident iir_rd", irq, 1);
        wait_idle();

        // Interrupt disabled
        thre_ie = 1'b0;
        burst(1);
        @(negedge clk);
        chk(thre == 1'b1, "R6 thre set with irq disabled", thre, 1);
        chk(irq == 1'b0, "R8 irq masked", irq, 0);
        wait_idle();
        thre_ie = 1'b1;

        // Format change mid-character
        burst(1);
        repeat (20) @(negedge clk);
        len_sel = 2'd0; par_en = 1'b1; stop2 = 1'b1;
        wait_idle();
        chk(q_len.size() == 0, "R11 character kept its captured format", q_len.size(), 0);

        // Random formats, divisors and bursts
        for (int it = 0; it < 20; it++) begin
            len_sel    = 2'($urandom);
            par_en     = 1'($urandom);
            par_even   = 1'($urandom);
            stop2      = 1'($urandom);
            dma_demand = 1'($urandom);
            divisor    = 16'(1 + ($urandom % 2));
            burst(1 + int'($urandom % 12));
            wait_idle();
        end
        chk(q_len.size() == 0, "R4/R5 random bursts fully sent", q_len.size(), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule